// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block drives the control pins of one 16-bit SDRAM device (13 row address lines, 9 column bits, 4 internal banks) from the moment reset is released. It first runs the power-up program: clock enable goes high, the device is given a long settling time, all banks are precharged, eight auto-refresh commands are issued, and the mode register is loaded. It then reports that the device is ready.

From that point the block is a refresh engine. An interval timer asks for one auto-refresh each time it expires. Every command is held back until the minimum gap that follows the previous command has elapsed (precharge recovery, row cycle time, mode-register settling). A refresh request that falls inside an open row-cycle window is counted and is issued later. Requests are never lost. Reads, writes, row and bank management and the data bus are outside this block.

The bring-up settling time, the gap lengths, the number of bring-up refreshes and the refresh interval are all parameters. This lets a bench shorten the settling time, which at 250 MHz is 25000 clocks.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge leaves `sd_cke` low, the command a NOP, `sd_addr` and `sd_ba` zero and `init_done` low. Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as NOP=0111, precharge=0010, auto-refresh=0001, load-mode=0000.
- R2: The first rising edge with `rst_n` high raises `sd_cke` with a NOP. `sd_cke` then stays high until the next reset.
- R3: Exactly `PWRUP_CYCLES` cycles after `sd_cke` rises, a precharge-all is issued with `sd_addr[10]` high.
- R4: `T_RP` cycles after the precharge, the first of `INIT_REFRESHES` (default 8) auto-refresh commands is issued. Each later one follows the previous one by exactly `T_RC` cycles.
- R5: `T_RC` cycles after the last bring-up refresh, a load-mode command is issued with `sd_ba` = 0 and `sd_addr` = 0x0220. In that word, bits 2:0 = 000 (burst length 1), bit 3 = 0 (sequential), bits 6:4 = 010 (CAS latency 2), bits 8:7 = 00 (standard mode) and bit 9 = 1 (single-location write burst).
- R6: `init_done` rises exactly `T_MRD` cycles after the load-mode command and stays high until reset.
- R7: Each command occupies exactly one cycle. Every other cycle carries a NOP with `sd_addr` = 0 and `sd_ba` = 0.
- R8: After `init_done` rises, a refresh request occurs every `REFRESH_PERIOD` cycles, the first one `REFRESH_PERIOD` cycles after the rise. A request is issued as an auto-refresh in its own cycle when at least `T_RC` cycles have passed since the previous auto-refresh.
- R9: A request that arrives before `T_RC` cycles have passed since the previous auto-refresh is kept pending. Pending requests are issued one per `T_RC` cycles, as early as the gap allows, and none is dropped.
- R10: While `init_done` is high, the only commands are NOP and auto-refresh.
- R11: A reset asserted at any point of the sequence restarts it from R1 and R2, with the full timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_BITS | Address lines (precharge-all flag, mode word) |
| sd_ba | output | BANK_BITS | Bank select, always zero |
| init_done | output | 1 | Bring-up finished, refresh engine running |

## Verification
The bench runs the sequencer with a refresh interval shorter than the row cycle time. This makes requests pile up, so a design that kept a single pending flag, or that merged a new request with the one being issued, would show fewer auto-refreshes than the bench expects. Resets are placed at random points, including inside the settling wait and inside the refresh burst. A design that did not rewind its gap timer or its refresh counter would issue the precharge or the load-mode command at the wrong cycle. Every cycle is compared against an edge-indexed schedule, so an off-by-one gap, a missing precharge flag on bit 10, or a mode word with CAS latency or write-burst bits misplaced is caught at the exact cycle it occurs.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes the command pins are grouped {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_LMR = 4'b0000
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_RP,
        ST_INITREF,
        ST_MRD,
        ST_RUN
    } seq_state_e;

    // Builds the mode-register word from its fields.
    function automatic logic [15:0] build_mode_word(
        input logic [2:0] burst_code,
        input logic       interleaved,
        input logic [2:0] cas_lat,
        input logic       single_write
    );
        logic [15:0] w;
        w        = '0;
        w[2:0]   = burst_code;
        w[3]     = interleaved;
        w[6:4]   = cas_lat;
        w[9]     = single_write;
        return w;
    endfunction

    // Largest of four gap lengths, at least 1.
    function automatic int max_gap(input int a, input int b, input int c, input int d);
        int m;
        m = 1;
        if (a > m) m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sd_gap_timer.sv
// Countdown timer that enforces a minimum gap between SDRAM commands.
// On load it takes (gap - 1). done is high once the count reaches zero, so the
// next command lands exactly "gap" cycles after the loading command.
// Assumes every gap is at least one cycle.
module sd_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a command, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sd_refresh_timer.sv
// Free-running refresh interval timer. After start it pulses tick once every
// PERIOD cycles, the first pulse PERIOD cycles after start.
// Assumes PERIOD >= 2.
module sd_refresh_timer #(
    parameter int PERIOD = 677
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic tick
);
    localparam int PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] cnt_q;
    logic          run_q;

    // Arm on start, then reload after every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= PW'(PERIOD - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0)
                cnt_q <= PW'(PERIOD - 1);
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run_q && (cnt_q == '0);

endmodule

// File: rtl/sdram_bringup_seq.sv
// SDRAM power-up and refresh sequencer.
// Runs the bring-up program (CKE, settle, precharge-all, INIT_REFRESHES
// auto-refreshes, load-mode), then raises init_done and issues auto-refreshes
// on a periodic timer. Requests that arrive inside the row-cycle window are
// counted and issued later. Assumes ROW_BITS > 10 (bit 10 is the precharge-all
// flag) and that every gap parameter is at least 1.
module sdram_bringup_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_BITS       = 13,
    parameter int BANK_BITS      = 2,
    parameter int PWRUP_CYCLES   = 25000,
    parameter int T_RP           = 2,
    parameter int T_RC           = 6,
    parameter int T_MRD          = 2,
    parameter int INIT_REFRESHES = 8,
    parameter int REFRESH_PERIOD = 677,
    parameter int PEND_W         = 4,
    parameter logic [2:0] BURST_CODE   = 3'b000,
    parameter logic [2:0] CAS_LATENCY  = 3'd2,
    parameter logic       SINGLE_WRITE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [ROW_BITS-1:0]  sd_addr,
    output logic [BANK_BITS-1:0] sd_ba,
    output logic                 init_done
);
    localparam int AP_BIT  = 10;
    localparam int MAXG    = max_gap(PWRUP_CYCLES, T_RP, T_RC, T_MRD);
    localparam int GAP_W   = (MAXG > 2) ? $clog2(MAXG) : 1;
    localparam int RCNT_W  = $clog2(INIT_REFRESHES + 1);
    localparam int MIN_CMD_GAP = (T_RP < T_MRD) ? ((T_RP < T_RC) ? T_RP : T_RC)
                                                : ((T_MRD < T_RC) ? T_MRD : T_RC);
    localparam logic [15:0]         MODE_FULL = build_mode_word(BURST_CODE, 1'b0, CAS_LATENCY, SINGLE_WRITE);
    localparam logic [ROW_BITS-1:0] MODE_WORD = MODE_FULL[ROW_BITS-1:0];

    seq_state_e          state_q, state_d;
    sd_cmd_e             cmd_q, cmd_d;
    logic [ROW_BITS-1:0] addr_q, addr_d;
    logic                cke_q, cke_d;
    logic                done_q, done_d;
    logic [RCNT_W-1:0]   rcnt_q, rcnt_d;
    logic [PEND_W-1:0]   pend_q, pend_d;
    logic                gap_load, gap_done;
    logic [GAP_W-1:0]    gap_val;
    logic                tmr_start, tick, run_issue;

    sd_gap_timer #(.CNT_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .done(gap_done)
    );

    sd_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_rtmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .tick(tick)
    );

    // Next-state and command selection for the bring-up program and refresh.
    always_comb begin
        state_d   = state_q;
        cmd_d     = CMD_NOP;
        addr_d    = '0;
        cke_d     = cke_q;
        done_d    = done_q;
        rcnt_d    = rcnt_q;
        gap_load  = 1'b0;
        gap_val   = '0;
        tmr_start = 1'b0;
        run_issue = 1'b0;
        case (state_q)
            ST_IDLE: begin
                cke_d    = 1'b1;
                gap_load = 1'b1;
                gap_val  = GAP_W'(PWRUP_CYCLES - 1);
                state_d  = ST_PWRUP;
            end
            ST_PWRUP: if (gap_done) begin
                cmd_d          = CMD_PRE;
                addr_d[AP_BIT] = 1'b1;
                gap_load       = 1'b1;
                gap_val        = GAP_W'(T_RP - 1);
                state_d        = ST_RP;
            end
            ST_RP: if (gap_done) begin
                cmd_d    = CMD_REF;
                rcnt_d   = RCNT_W'(1);
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RC - 1);
                state_d  = ST_INITREF;
            end
            ST_INITREF: if (gap_done) begin
                gap_load = 1'b1;
                if (rcnt_q == RCNT_W'(INIT_REFRESHES)) begin
                    cmd_d   = CMD_LMR;
                    addr_d  = MODE_WORD;
                    gap_val = GAP_W'(T_MRD - 1);
                    state_d = ST_MRD;
                end else begin
                    cmd_d   = CMD_REF;
                    rcnt_d  = rcnt_q + 1'b1;
                    gap_val = GAP_W'(T_RC - 1);
                end
            end
            ST_MRD: if (gap_done) begin
                done_d    = 1'b1;
                tmr_start = 1'b1;
                state_d   = ST_RUN;
            end
            ST_RUN: if ((tick || pend_q != '0) && gap_done) begin
                cmd_d     = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RC - 1);
                run_issue = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pending-request count: +1 per tick, -1 per issued refresh, saturating.
    always_comb begin
        pend_d = pend_q;
        if (tick && !run_issue && pend_q != '1)
            pend_d = pend_q + 1'b1;
        else if (!tick && run_issue)
            pend_d = pend_q - 1'b1;
    end

    // Sequencer registers; outputs come straight from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            rcnt_q  <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            cke_q   <= cke_d;
            done_q  <= done_d;
            rcnt_q  <= rcnt_d;
            pend_q  <= pend_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_addr   = addr_q;
    assign sd_ba     = '0;
    assign sd_cke    = cke_q;
    assign init_done = done_q;

    // ---------------- assertions ----------------
    localparam int AGE_W = $clog2(T_RC + 1);
    logic [AGE_W-1:0] ref_age_q;
    logic             ref_seen_q;

    // Cycles since the last auto-refresh on the pins, saturating at T_RC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_age_q  <= '0;
            ref_seen_q <= 1'b0;
        end else if (cmd_q == CMD_REF) begin
            ref_age_q  <= AGE_W'(1);
            ref_seen_q <= 1'b1;
        end else if (ref_age_q < AGE_W'(T_RC)) begin
            ref_age_q  <= ref_age_q + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!sd_cke && cmd_q == CMD_NOP && !init_done && sd_addr == '0));

    a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> (sd_addr[AP_BIT] && sd_cke && !init_done));

    a_r4_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF && ref_seen_q) |-> (ref_age_q >= AGE_W'(T_RC)));

    a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_LMR) |-> (sd_addr == MODE_WORD && !init_done && ref_age_q >= AGE_W'(T_RC)));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r10_run_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd_q == CMD_NOP || cmd_q == CMD_REF));

    generate
        if (MIN_CMD_GAP > 1) begin : g_single_cycle
            a_r7_one_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));
        end
    endgenerate

endmodule

// File: tb/sdram_bringup_seq_test.sv
// Bench for the SDRAM bring-up sequencer: random reset points and lengths plus
// directed segments, compared each cycle against a schedule model.
module sdram_bringup_seq_test;

    localparam int W     = 40;
    localparam int RP    = 2;
    localparam int RC    = 6;
    localparam int MRD   = 2;
    localparam int NREF  = 8;
    localparam int PER   = 5;
    localparam int LM_AT = W + RP + NREF * RC;
    localparam int D_AT  = LM_AT + MRD;
    localparam logic [3:0]  C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;
    localparam logic [12:0] MODE_EXP = 13'h0220;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // model state
    int          e;
    int          pend;
    int          last_ref;
    int          seg_idx;
    bit          valid = 1'b0;
    logic        x_cke, x_done;
    logic [3:0]  x_cmd;
    logic [12:0] x_addr;
    string       x_tag, x_cke_tag, x_done_tag;

    sdram_bringup_seq #(
        .PWRUP_CYCLES(W), .T_RP(RP), .T_RC(RC), .T_MRD(MRD),
        .INIT_REFRESHES(NREF), .REFRESH_PERIOD(PER), .PEND_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .init_done(init_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at t=%0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Expected outputs after the coming rising edge.
    task automatic model_step(input bit in_reset);
        if (in_reset) begin
            e = 0; pend = 0; last_ref = -1000;
            x_cke = 1'b0; x_cmd = C_NOP; x_addr = '0; x_done = 1'b0;
            x_tag = "R1"; x_cke_tag = "R1"; x_done_tag = "R1";
            return;
        end
        x_cke = 1'b1; x_cmd = C_NOP; x_addr = '0;
        x_done = (e >= D_AT);
        x_tag = x_done ? "R10" : "R7";
        x_cke_tag = (e == 0 && seg_idx > 0) ? "R11" : "R2";
        x_done_tag = "R6";
        if (e == W) begin x_cmd = C_PRE; x_addr = 13'h0400; x_tag = "R3"; end
        for (int k = 0; k < NREF; k++)
            if (e == W + RP + k * RC) begin x_cmd = C_REF; x_tag = "R4"; last_ref = e; end
        if (e == LM_AT) begin x_cmd = C_LMR; x_addr = MODE_EXP; x_tag = "R5"; end
        if (e > D_AT) begin
            bit tk;
            tk = ((e - D_AT) % PER) == 0;
            if ((tk || pend > 0) && (e - last_ref >= RC)) begin
                x_cmd = C_REF;
                x_tag = (tk && pend == 0) ? "R8" : "R9";
                pend = pend + (tk ? 1 : 0) - 1;
                last_ref = e;
            end else begin
                pend = pend + (tk ? 1 : 0);
            end
        end
        e++;
    endtask

    // One cycle: check the last edge's outputs, then drive reset for the next.
    task automatic cycle(input bit hold_reset);
        @(negedge clk);
        if (valid) begin
            chk(x_cke_tag, 32'(sd_cke), 32'(x_cke));
            chk(x_tag, 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(x_cmd));
            chk(x_tag, 32'(sd_addr), 32'(x_addr));
            chk(x_tag, 32'(sd_ba), 32'd0);
            chk(x_done_tag, 32'(init_done), 32'(x_done));
        end
        rst_n = hold_reset ? 1'b0 : 1'b1;
        model_step(hold_reset);
        valid = 1'b1;
    endtask

    task automatic segment(input int rst_len, input int run_len);
        for (int i = 0; i < rst_len; i++) cycle(1'b1);
        for (int i = 0; i < run_len; i++) cycle(1'b0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        seg_idx = 0;
        // R1/R2..R9: full bring-up and a long refresh run with backlog
        segment(3, D_AT + 300);
        // R11: reset in the settling wait
        seg_idx = 1;
        segment(2, W);
        // R11: reset inside the bring-up refresh burst
        seg_idx = 2;
        segment(1, W + RP + 3 * RC + 2);
        // R11: reset right after load-mode
        seg_idx = 3;
        segment(1, LM_AT + 1);
        // random reset lengths and reset points
        for (int s = 0; s < 6; s++) begin
            seg_idx = 4 + s;
            segment(1 + int'($urandom_range(3)), 1 + int'($urandom_range(D_AT + 250)));
        end
        seg_idx = 10;
        segment(2, D_AT + 60);
        cycle(1'b1);
        cycle(1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule